// File: doc/BRIEF.md
# Transmit Frame Finisher

This block sits between the transmit buffer write path and the line side of an Ethernet controller. The host pushes the bytes of a frame into a valid/ready input stream after it has programmed the frame length and the transmit command options. The block forwards the bytes on a valid/ready output stream. When a frame is short, it extends the frame to the 60-byte Ethernet minimum with zero bytes and then appends a 4-byte frame check sequence. Separate command bits can disable the padding or the check sequence.

When the final byte of a frame is accepted downstream, the block records the length the frame had on the wire. It also sets its transmit event word to the success value and, if enabled, raises a one-cycle interrupt pulse. If the line transmit enable is off when the first byte of a frame arrives, the block still consumes the whole frame but sends nothing.

Back-pressure: a byte moves on either stream only in a cycle where valid and ready are both high. While out_valid is high and out_ready is low, the output byte and out_last hold steady. Body bytes pass straight through, so while the body of a frame is streaming, in_ready follows out_ready. While fill or check bytes are being emitted, in_ready is held low, so the next frame waits until the current frame's last byte has gone out.

Top module: `tx_frame_finisher`

## Requirements
- R1: Body bytes leave in arrival order with their values unchanged. A byte that is offered downstream but not taken holds its value, and holds out_last, until out_ready is high.
- R2: If line_tx_en is low when the first byte of a frame is accepted, the block consumes all prog_len bytes of that frame and never raises out_valid for it. In that case final_len, tx_event and tx_irq do not change.
- R3: A frame with prog_len of 60 or less, with pad_dis low, is followed by zero bytes until exactly 60 bytes have been sent.
- R4: After the padding, unless crc_inh is set, 4 check bytes follow, for 64 bytes in total. The check value is the Ethernet CRC-32 (reflected polynomial 0xEDB88320, start value all ones, result complemented) over the 60 bytes, sent least-significant byte first.
- R5: A frame with prog_len of 60 or less, with pad_dis high, is sent at its own length with no fill and no check bytes, whatever the value of crc_inh.
- R6: A frame with prog_len above 60 is sent at exactly prog_len bytes with nothing added.
- R7: out_last is high on the final byte of each frame and on no other byte.
- R8: One cycle after the final byte is accepted, final_len holds the number of bytes the frame had on the wire.
- R9: tx_event is 0x0008 after reset and after a one-cycle evt_ack pulse. The cycle after a frame completes, tx_event is overwritten with exactly 0x0108. A completion wins over evt_ack in the same cycle.
- R10: tx_irq pulses high for one cycle, in the cycle after completion, exactly when txok_irq_en is high. Otherwise it stays low.
- R11: in_ready is low while fill or check bytes are being emitted. prog_len, line_tx_en, pad_dis and crc_inh are taken once, when the first byte of a frame is accepted; changing them later within that frame has no effect.
- R12: After reset, out_valid and tx_irq are low, final_len is 0 and tx_event is 0x0008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_tx_en | input | 1 | Line transmit enable, sampled at the first byte |
| pad_dis | input | 1 | Suppress zero fill of short frames |
| crc_inh | input | 1 | Suppress the appended check bytes |
| txok_irq_en | input | 1 | Allow tx_irq on completion |
| evt_ack | input | 1 | Return tx_event to its idle value |
| prog_len | input | 11 | Programmed frame length in bytes, 1 to 1518 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final byte of a frame |
| final_len | output | 11 | Wire length of the last completed frame |
| tx_event | output | 16 | Transmit event word |
| tx_irq | output | 1 | One-cycle completion interrupt |

## Verification
The assertions assume that the input stream follows the same holding rule as the output: once in_valid is raised, it stays high with in_data unchanged until the byte is accepted. They also assume that prog_len lies between 1 and 1518, and that the configuration inputs stay steady while a frame's first byte waits to be accepted. The stimulus raises in_valid at random but drops it only after an accepted handshake. It toggles out_ready freely every cycle, draws lengths inside the legal range, and changes the configuration only after a frame's first byte has been taken.

// File: rtl/txfin_pkg.sv
package txfin_pkg;

  typedef enum logic [1:0] {
    PH_BODY,
    PH_FILL,
    PH_FCS
  } phase_t;

  localparam logic [15:0] EVT_IDLE = 16'h0008;
  localparam logic [15:0] EVT_OK   = 16'h0108;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  // One byte of reflected CRC-32, low bit first.
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/txfin_crc.sv
module txfin_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        step,
  input  logic [7:0]  din,
  output logic [31:0] state
);
  import txfin_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= '1;
    else if (restart) state <= '1;
    else if (step)    state <= crc_byte(state, din);
  end
endmodule

// File: rtl/txfin_seq.sv
module txfin_seq #(
  parameter int LEN_W     = 11,
  parameter int MIN_BODY  = 60,
  parameter int FCS_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_tx_en,
  input  logic             pad_dis,
  input  logic             crc_inh,
  input  logic [LEN_W-1:0] prog_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic [31:0]      crc_state,
  output logic             crc_step,
  output logic             frame_done,
  output logic [LEN_W-1:0] wire_len,
  output logic             tail
);
  import txfin_pkg::*;

  localparam int IDX_W = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
  localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_BODY);
  localparam logic [IDX_W-1:0] FCS_LI = IDX_W'(FCS_BYTES - 1);

  phase_t           phase;
  logic [LEN_W-1:0] cnt, len_q;
  logic             drop_q, pad_q, crc_q;

  logic             first, body_end;
  logic [LEN_W-1:0] eff_len;
  logic             eff_drop, eff_pad, eff_crc;
  logic [LEN_W-1:0] fcs_off;
  logic [IDX_W-1:0] fcs_idx;

  assign first    = (phase == PH_BODY) && (cnt == '0);
  assign eff_len  = first ? prog_len : len_q;
  assign eff_drop = first ? !line_tx_en : drop_q;
  assign eff_pad  = first ? ((prog_len <= MIN_L) && !pad_dis) : pad_q;
  assign eff_crc  = first ? !crc_inh : crc_q;
  assign body_end = (cnt + 1'b1) == eff_len;
  assign fcs_off  = cnt - MIN_L;
  assign fcs_idx  = fcs_off[IDX_W-1:0];
  assign wire_len = cnt + 1'b1;
  assign tail     = (phase != PH_BODY);

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_last  = 1'b0;
    crc_step  = 1'b0;
    case (phase)
      PH_BODY: begin
        in_ready  = eff_drop | out_ready;
        out_valid = in_valid & !eff_drop;
        out_data  = in_data;
        out_last  = body_end && !(eff_pad && ((eff_len < MIN_L) || eff_crc));
        crc_step  = out_valid & out_ready;
      end
      PH_FILL: begin
        out_valid = 1'b1;
        out_last  = ((cnt + 1'b1) == MIN_L) && !crc_q;
        crc_step  = out_ready;
      end
      default: begin
        out_valid = 1'b1;
        out_data  = ~crc_state[int'(fcs_idx)*8 +: 8];
        out_last  = (fcs_idx == FCS_LI);
      end
    endcase
  end

  assign frame_done = out_valid & out_ready & out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_BODY;
      cnt    <= '0;
      len_q  <= '0;
      drop_q <= 1'b0;
      pad_q  <= 1'b0;
      crc_q  <= 1'b0;
    end else begin
      case (phase)
        PH_BODY: if (in_valid && in_ready) begin
          if (first) begin
            len_q  <= prog_len;
            drop_q <= !line_tx_en;
            pad_q  <= (prog_len <= MIN_L) && !pad_dis;
            crc_q  <= !crc_inh;
          end
          if (!body_end)                          cnt <= cnt + 1'b1;
          else if (eff_drop)                      cnt <= '0;
          else if (eff_pad && (eff_len < MIN_L)) begin
            phase <= PH_FILL;
            cnt   <= cnt + 1'b1;
          end else if (eff_pad && eff_crc) begin
            phase <= PH_FCS;
            cnt   <= cnt + 1'b1;
          end else                                cnt <= '0;
        end
        PH_FILL: if (out_ready) begin
          if ((cnt + 1'b1) != MIN_L) cnt <= cnt + 1'b1;
          else if (crc_q) begin
            phase <= PH_FCS;
            cnt   <= cnt + 1'b1;
          end else begin
            phase <= PH_BODY;
            cnt   <= '0;
          end
        end
        default: if (out_ready) begin
          if (out_last) begin
            phase <= PH_BODY;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/txfin_status.sv
module txfin_status #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic [LEN_W-1:0] wire_len,
  input  logic             txok_irq_en,
  input  logic             evt_ack,
  output logic [LEN_W-1:0] final_len,
  output logic [15:0]      tx_event,
  output logic             tx_irq
);
  import txfin_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      final_len <= '0;
      tx_event  <= EVT_IDLE;
      tx_irq    <= 1'b0;
    end else begin
      tx_irq <= frame_done & txok_irq_en;
      if (frame_done) begin
        final_len <= wire_len;
        tx_event  <= EVT_OK;
      end else if (evt_ack) begin
        tx_event  <= EVT_IDLE;
      end
    end
  end
endmodule

// File: rtl/tx_frame_finisher.sv
module tx_frame_finisher #(
  parameter int MAX_LEN   = 1518,
  parameter int MIN_BODY  = 60,
  parameter int FCS_BYTES = 4,
  localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_tx_en,
  input  logic             pad_dis,
  input  logic             crc_inh,
  input  logic             txok_irq_en,
  input  logic             evt_ack,
  input  logic [LEN_W-1:0] prog_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [LEN_W-1:0] final_len,
  output logic [15:0]      tx_event,
  output logic             tx_irq
);
  logic [31:0]      crc_state;
  logic             crc_step, frame_done, tail;
  logic [LEN_W-1:0] wire_len;

  txfin_seq #(.LEN_W(LEN_W), .MIN_BODY(MIN_BODY), .FCS_BYTES(FCS_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_tx_en(line_tx_en), .pad_dis(pad_dis),
    .crc_inh(crc_inh), .prog_len(prog_len), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .crc_state(crc_state), .crc_step(crc_step), .frame_done(frame_done),
    .wire_len(wire_len), .tail(tail)
  );

  txfin_crc u_crc (
    .clk(clk), .rst_n(rst_n), .restart(frame_done), .step(crc_step),
    .din(out_data), .state(crc_state)
  );

  txfin_status #(.LEN_W(LEN_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .wire_len(wire_len),
    .txok_irq_en(txok_irq_en), .evt_ack(evt_ack), .final_len(final_len),
    .tx_event(tx_event), .tx_irq(tx_irq)
  );
endmodule

// File: rtl/tx_frame_finisher_chk.sv
module tx_frame_finisher_chk #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last,
  input logic [LEN_W-1:0] final_len,
  input logic [15:0]      tx_event,
  input logic             tx_irq,
  input logic             tail
);
  logic [LEN_W-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beats <= '0;
    else if (out_valid && out_ready) beats <= out_last ? '0 : beats + 1'b1;
  end

  a_r1_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r11_no_accept_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
    tail |-> !in_ready);

  a_r9_event_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> tx_event == 16'h0108);

  a_r8_len_matches_beats: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> final_len == $past(beats) + 1'b1);

  a_r10_irq_with_event: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_event == 16'h0108);
endmodule

bind tx_frame_finisher tx_frame_finisher_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .final_len(final_len), .tx_event(tx_event), .tx_irq(tx_irq), .tail(tail)
);

// File: tb/tx_frame_finisher_test.sv
module tx_frame_finisher_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL = 1518;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_tx_en = 1'b1, pad_dis = 1'b0, crc_inh = 1'b0, txok_irq_en = 1'b0, evt_ack = 1'b0;
  logic [10:0] prog_len = '0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, out_last, tx_irq;
  logic [7:0] in_data = '0, out_data;
  logic [10:0] final_len;
  logic [15:0] tx_event;

  int compared = 0, mismatched = 0, cyc = 0, irq_seen = 0;
  bit timeout = 0;
  logic [7:0] src [0:2047];
  logic [7:0] expb[0:2047];
  logic [7:0] got [0:2047];

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_frame_finisher uut (
    .clk(clk), .rst_n(rst_n), .line_tx_en(line_tx_en), .pad_dis(pad_dis),
    .crc_inh(crc_inh), .txok_irq_en(txok_irq_en), .evt_ack(evt_ack),
    .prog_len(prog_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .final_len(final_len),
    .tx_event(tx_event), .tx_irq(tx_irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) timeout <= 1'b1;
  end
  always @(negedge clk) if (rst_n && tx_irq) irq_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, expb[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic int build_expect(input int len, input bit pd, input bit ci, input bit le);
    int n;
    logic [31:0] f;
    if (!le) return 0;
    for (int i = 0; i < len; i++) expb[i] = src[i];
    n = len;
    if (len <= 60 && !pd) begin
      for (int i = len; i < 60; i++) expb[i] = 8'h00;
      n = 60;
      if (!ci) begin
        f = ref_fcs(60);
        for (int i = 0; i < 4; i++) expb[60+i] = f[8*i +: 8];
        n = 64;
      end
    end
    return n;
  endfunction

  task automatic run_frame(input int len, input bit pd, input bit ci, input bit le,
                           input bit ie, input bit twiddle);
    int idx = 0, nout = 0, lastcnt = 0, last_pos = -1, holdviol = 0, exp_n, bad = 0, first_bad = -1;
    int irq0;
    logic [15:0] ev0;
    logic [10:0] fl0;
    bit clr = 0, fin = 0;
    string tag;
    for (int i = 0; i < len; i++) src[i] = 8'($urandom);
    exp_n = build_expect(len, pd, ci, le);
    if (!le) tag = "R2";
    else if (len > 60) tag = "R6";
    else if (pd) tag = "R5";
    else tag = "R3,R4";
    @(negedge clk);
    prog_len = 11'(len); pad_dis = pd; crc_inh = ci; line_tx_en = le; txok_irq_en = ie;
    ev0 = tx_event; fl0 = final_len; irq0 = irq_seen;
    while (!fin && !timeout) begin
      @(negedge clk);
      if (clr) begin in_valid = 1'b0; clr = 0; end
      if (twiddle && idx == 1) begin
        pad_dis = ~pd; crc_inh = ~ci; line_tx_en = ~le; prog_len = 11'(len + 7);
      end
      if (!in_valid && idx < len) begin
        in_valid = ($urandom % 4) != 0;
        in_data = src[idx];
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      if (nout >= len && in_ready) holdviol++;
      if (out_valid && out_ready) begin
        got[nout] = out_data;
        if (out_last) begin lastcnt++; last_pos = nout; end
        nout++;
      end
      if (in_valid && in_ready) begin idx++; clr = 1; end
      if (le && lastcnt > 0) fin = 1;
      if (!le && idx == len) fin = 1;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    pad_dis = pd; crc_inh = ci; line_tx_en = 1'b1;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < exp_n && i < nout; i++)
      if (got[i] !== expb[i]) begin bad++; if (first_bad < 0) first_bad = i; end
    chk({tag, " byte count"}, 32'(nout), 32'(exp_n));
    chk({tag, " R1 byte values, bad count"}, 32'(bad), 32'd0);
    if (bad > 0) $display("  first differing byte at %0d", first_bad);
    chk("R7 last count", 32'(lastcnt), (exp_n > 0) ? 32'd1 : 32'd0);
    if (exp_n > 0) chk("R7 last position", 32'(last_pos), 32'(exp_n - 1));
    chk("R8 final_len", 32'(final_len), le ? 32'(exp_n) : 32'(fl0));
    chk("R9 tx_event", 32'(tx_event), le ? 32'h0108 : 32'(ev0));
    chk("R10 irq pulses", 32'(irq_seen - irq0), (le && ie) ? 32'd1 : 32'd0);
    chk("R11 in_ready during tail", 32'(holdviol), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd24680));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk("R12 out_valid", 32'(out_valid), 32'd0);
    chk("R12 tx_event", 32'(tx_event), 32'h0008);
    chk("R12 final_len", 32'(final_len), 32'd0);
    chk("R12 tx_irq", 32'(tx_irq), 32'd0);
    chk("R12 in_ready", 32'(in_ready), 32'd1);

    run_frame(1, 0, 0, 1, 1, 0);
    run_frame(59, 0, 0, 1, 0, 0);
    run_frame(60, 0, 0, 1, 1, 0);
    run_frame(60, 0, 1, 1, 1, 0);
    run_frame(30, 0, 1, 1, 1, 0);
    run_frame(30, 1, 0, 1, 1, 0);
    run_frame(60, 1, 0, 1, 0, 0);
    run_frame(61, 0, 0, 1, 1, 0);
    run_frame(20, 0, 0, 0, 1, 0);
    run_frame(MAXL, 0, 0, 1, 1, 0);
    run_frame(10, 0, 0, 1, 1, 1);
    run_frame(12, 0, 0, 0, 1, 1);

    // R9: acknowledge returns the event word to idle
    @(negedge clk); evt_ack = 1'b1;
    @(negedge clk); evt_ack = 1'b0;
    chk("R9 ack to idle", 32'(tx_event), 32'h0008);

    for (int n = 0; n < 40 && !timeout; n++) begin
      int len = 1 + int'($urandom % 130);
      run_frame(len, ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 6) != 0,
                $urandom % 2, ($urandom % 8) == 0);
    end

    if (timeout) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule